// File: doc/BRIEF.md
# Multi-Channel Request Router with Response Harvesting

This block sits between a host and a set of child channels on a coprocessor side. The host submits 32-bit request words through a small write window. The low nibble of each word names the target channel. A request for an idle channel is handed straight to that channel as a one-cycle strobe that carries the word unchanged. A request for a channel that reports itself busy is parked whole in a small holding queue. A request that names a channel that does not exist is thrown away. A request that arrives while the holding queue is full is also thrown away. Each rejected request raises a one-cycle error pulse. The host can read the fill state of the holding queue as a status word. Draining the parked words back to the channels is left to logic outside this block, which reaches the queue through a pop port.

In the other direction, the block collects responses from the channels. Each channel shows a data-ready flag and its current response word. On each cycle the block takes at most one response. It takes it from the lowest-numbered ready channel, and only if the host receive queue has room. So channel 0 is emptied before channel 1 gets any turn, and collection stops while the receive queue is full. The host drains the receive queue in arrival order.

Top module: `mbr_router`

## Requirements
- R1: A write is a submission only when its address is 0xA0, 0xA4, 0xA8 or 0xAC. Any other write address causes no delivery, no parking and no error pulse. The target channel is bits [3:0] of the written word.
- R2: A submission to a valid, idle channel sets bit `ch` of `dlv_valid` for exactly the cycle after the write. In that same cycle `dlv_data` holds the whole written word unchanged. Only one bit of `dlv_valid` is ever high.
- R3: A submission to a valid channel whose `chan_busy` bit is set is not delivered. The whole word is appended to the holding queue, and `park_data` shows the oldest parked word.
- R4: When the holding queue is full, a submission is dropped, even if its channel is idle. `sub_err` pulses for one cycle, the cycle after the write.
- R5: A submission whose channel number is not below NCH is discarded. It is neither delivered nor parked, and `sub_err` pulses for one cycle.
- R6: In a cycle where the receive queue is not full, `rsp_pop` is one-hot on the lowest-indexed channel with `chan_avail` set. That channel's `rsp_data` word enters the receive queue at the clock edge. At most one response is taken per cycle.
- R7: While `rx_full` is high, `rsp_pop` stays zero.
- R8: When `rd_addr` is 0xB8, `rd_data` reads bit 31 = holding queue full, bit 30 = holding queue empty and bits [7:0] = number of parked words. All other bits are zero. Any other read address returns zero.
- R9: While reset is low, and right after it, both queues are empty. No delivery, error pulse or response pop occurs during reset, whatever the channel inputs are.
- R10: The host pops the receive queue in first-in first-out order with `rx_pop`. `rx_empty` and `rx_full` reflect its fill level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 8 | Host write offset |
| wr_data | input | 32 | Host write word |
| rd_addr | input | 8 | Host read offset (combinational read) |
| rd_data | output | 32 | Read data: holding queue status at 0xB8 |
| chan_busy | input | NCH | Per-channel busy/pending flag |
| chan_avail | input | NCH | Per-channel response-ready flag |
| rsp_data | input | NCH*32 | Per-channel current response word, channel i at [32i+31:32i] |
| rsp_pop | output | NCH | One-hot response read strobe |
| dlv_valid | output | NCH | One-hot deliver strobe |
| dlv_data | output | 32 | Delivered word |
| sub_err | output | 1 | Dropped or invalid submission pulse |
| rx_pop | input | 1 | Host pop of the receive queue |
| rx_data | output | 32 | Head of the receive queue |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| park_pop | input | 1 | Pop of the holding queue |
| park_data | output | 32 | Head of the holding queue |

## Verification
The bench loads several channels at once so that the collection order is exposed. A picker that favoured the highest index, or one that rotated between channels, would put words into the receive queue out of the expected order. It keeps the receive queue full for many cycles while channels still hold data. A design that ignored the full condition would pop responses that have nowhere to go, and would lose them. It submits to an idle channel while the holding queue is full. A design that tested busy or channel validity before fullness would deliver that word instead of dropping it. It also writes to addresses just outside the window and to channel numbers 9 and 15. A loose address decode, or a channel check written as less-or-equal, would then deliver or park words that should vanish.

// File: rtl/mbr_pkg.sv
package mbr_pkg;
   localparam int WORD_W     = 32;
   localparam int ADDR_W     = 8;
   localparam int SEL_W      = 4;
   localparam logic [ADDR_W-1:0] WIN_LO   = 8'hA0;
   localparam logic [ADDR_W-1:0] WIN_HI   = 8'hAC;
   localparam logic [ADDR_W-1:0] STAT_OFF = 8'hB8;

   // status word: full flag, empty flag, level in the low byte
   function automatic logic [WORD_W-1:0] stat_word(input logic full,
                                                   input logic empty,
                                                   input logic [7:0] level);
      return {full, empty, 22'd0, level};
   endfunction
endpackage

// File: rtl/mbr_fifo.sv
module mbr_fifo #(
   parameter int W = 32,
   parameter int D = 4,
   localparam int AW = (D > 1) ? $clog2(D) : 1,
   localparam int CW = $clog2(D + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] count
);
   logic [W-1:0]  mem [D];
   logic [AW-1:0] wp, rp;
   logic          do_push, do_pop;

   assign do_push = push && (count != CW'(D));
   assign do_pop  = pop && (count != '0);
   assign dout    = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_push) wp <= (wp == AW'(D - 1)) ? '0 : wp + 1'b1;
         if (do_pop)  rp <= (rp == AW'(D - 1)) ? '0 : rp + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/mbr_pick.sv
module mbr_pick #(
   parameter int N = 9
) (
   input  logic         en,
   input  logic [N-1:0] req,
   output logic [N-1:0] grant
);
   logic [N:0] seen;
   assign seen[0] = 1'b0;
   for (genvar i = 0; i < N; i++) begin : g_chain
      assign grant[i]    = en & req[i] & ~seen[i];
      assign seen[i + 1] = seen[i] | req[i];
   end
endmodule

// File: rtl/mbr_submit.sv
module mbr_submit
   import mbr_pkg::*;
#(
   parameter int NCH = 9
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [SEL_W-1:0]  sel,
   input  logic [NCH-1:0]    chan_busy,
   input  logic              park_full,
   output logic [NCH-1:0]    dlv_now,
   output logic              park_push,
   output logic              err_now
);
   localparam int SPAN = 1 << SEL_W;

   logic            in_win, ch_ok, accept, tgt_busy;
   logic [SPAN-1:0] busy_ext, sel_hot;

   assign in_win   = wr_en && (wr_addr >= WIN_LO) && (wr_addr <= WIN_HI)
                     && (wr_addr[1:0] == 2'b00);
   assign ch_ok    = (int'(sel) < NCH);
   assign busy_ext = SPAN'(chan_busy);
   assign tgt_busy = busy_ext[sel];
   assign sel_hot  = SPAN'(1) << sel;

   // fullness is tested first: a full queue drops even idle-channel words
   assign accept    = in_win & ~park_full & ch_ok;
   assign park_push = accept & tgt_busy;
   assign dlv_now   = (accept & ~tgt_busy) ? sel_hot[NCH-1:0] : '0;
   assign err_now   = in_win & (park_full | ~ch_ok);
endmodule

// File: rtl/mbr_router.sv
module mbr_router
   import mbr_pkg::*;
#(
   parameter int NCH        = 9,
   parameter int PARK_DEPTH = 4,
   parameter int RX_DEPTH   = 8,
   localparam int PCW = $clog2(PARK_DEPTH + 1),
   localparam int RCW = $clog2(RX_DEPTH + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [7:0]            wr_addr,
   input  logic [31:0]           wr_data,
   input  logic [7:0]            rd_addr,
   output logic [31:0]           rd_data,
   input  logic [NCH-1:0]        chan_busy,
   input  logic [NCH-1:0]        chan_avail,
   input  logic [NCH*32-1:0]     rsp_data,
   output logic [NCH-1:0]        rsp_pop,
   output logic [NCH-1:0]        dlv_valid,
   output logic [31:0]           dlv_data,
   output logic                  sub_err,
   input  logic                  rx_pop,
   output logic [31:0]           rx_data,
   output logic                  rx_empty,
   output logic                  rx_full,
   input  logic                  park_pop,
   output logic [31:0]           park_data
);
   if (NCH < 1 || NCH > (1 << SEL_W)) begin : g_bad_nch
      $error("mbr_router: NCH must lie in 1..16");
   end
   if (PARK_DEPTH < 2 || PARK_DEPTH > 255) begin : g_bad_park
      $error("mbr_router: PARK_DEPTH must lie in 2..255");
   end
   if (RX_DEPTH < 2) begin : g_bad_rx
      $error("mbr_router: RX_DEPTH must be at least 2");
   end

   logic [PCW-1:0]    park_cnt;
   logic [RCW-1:0]    rx_cnt;
   logic              park_full, park_empty;
   logic              park_push, err_now;
   logic [NCH-1:0]    dlv_now;
   logic [WORD_W-1:0] harvest_word;

   assign park_full  = (park_cnt == PCW'(PARK_DEPTH));
   assign park_empty = (park_cnt == '0);
   assign rx_full    = (rx_cnt == RCW'(RX_DEPTH));
   assign rx_empty   = (rx_cnt == '0);

   mbr_submit #(.NCH(NCH)) u_sub (
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .sel       (wr_data[SEL_W-1:0]),
      .chan_busy (chan_busy),
      .park_full (park_full),
      .dlv_now   (dlv_now),
      .park_push (park_push),
      .err_now   (err_now)
   );

   mbr_fifo #(.W(WORD_W), .D(PARK_DEPTH)) u_park (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (park_push),
      .din   (wr_data),
      .pop   (park_pop),
      .dout  (park_data),
      .count (park_cnt)
   );

   // collection is suppressed in reset and while the receive queue is full
   mbr_pick #(.N(NCH)) u_pick (
      .en    (rst_n & ~rx_full),
      .req   (chan_avail),
      .grant (rsp_pop)
   );

   always_comb begin
      harvest_word = '0;
      for (int i = 0; i < NCH; i++) begin
         if (rsp_pop[i]) harvest_word |= rsp_data[i*WORD_W +: WORD_W];
      end
   end

   mbr_fifo #(.W(WORD_W), .D(RX_DEPTH)) u_rx (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (|rsp_pop),
      .din   (harvest_word),
      .pop   (rx_pop),
      .dout  (rx_data),
      .count (rx_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dlv_valid <= '0;
         dlv_data  <= '0;
         sub_err   <= 1'b0;
      end else begin
         dlv_valid <= dlv_now;
         sub_err   <= err_now;
         if (|dlv_now) dlv_data <= wr_data;
      end
   end

   assign rd_data = (rd_addr == STAT_OFF)
                    ? stat_word(park_full, park_empty, 8'(park_cnt))
                    : '0;
endmodule

// File: rtl/mbr_checker.sv
module mbr_checker #(
   parameter int NCH = 9
) (
   input logic           clk,
   input logic           rst_n,
   input logic           wr_en,
   input logic [7:0]     wr_addr,
   input logic [7:0]     rd_addr,
   input logic [31:0]    rd_data,
   input logic [NCH-1:0] chan_avail,
   input logic [NCH-1:0] rsp_pop,
   input logic [NCH-1:0] dlv_valid,
   input logic           sub_err,
   input logic           rx_full
);
   // R2: deliver strobe never targets two channels
   a_r2_dlv_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dlv_valid));

   // R1: a delivery follows a write inside the window
   a_r1_dlv_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (dlv_valid != '0) |-> $past(wr_en && wr_addr >= 8'hA0 && wr_addr <= 8'hAC));

   // R4 R5: an error pulse follows a write inside the window
   a_r4_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
      sub_err |-> $past(wr_en && wr_addr >= 8'hA0 && wr_addr <= 8'hAC));

   // R5: error and delivery never come together
   a_r5_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
      sub_err |-> (dlv_valid == '0));

   // R6: at most one response read per cycle, only from a ready channel
   a_r6_pop_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rsp_pop) && ((rsp_pop & ~chan_avail) == '0));

   // R6: the chosen channel is the lowest ready one
   a_r6_lowest: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_pop != '0) |-> (((rsp_pop - 1'b1) & chan_avail) == '0));

   // R7: no collection into a full receive queue
   a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      rx_full |-> (rsp_pop == '0));

   // R8: status never claims full and empty at once
   a_r8_stat_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == 8'hB8) |-> !(rd_data[31] && rd_data[30]));
endmodule

bind mbr_router mbr_checker #(.NCH(NCH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .rd_addr    (rd_addr),
   .rd_data    (rd_data),
   .chan_avail (chan_avail),
   .rsp_pop    (rsp_pop),
   .dlv_valid  (dlv_valid),
   .sub_err    (sub_err),
   .rx_full    (rx_full)
);

// File: tb/sim_mbr_router.sv
`timescale 1ns/1ps
module sim_mbr_router;
   localparam int NCH = 9;
   localparam int PD  = 4;
   localparam int RD  = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [7:0]        wr_addr = '0;
   logic [31:0]       wr_data = '0;
   logic [7:0]        rd_addr = 8'hB8;
   logic [31:0]       rd_data;
   logic [NCH-1:0]    chan_busy = '0;
   logic [NCH-1:0]    chan_avail = '0;
   logic [NCH*32-1:0] rsp_data = '0;
   logic [NCH-1:0]    rsp_pop, dlv_valid;
   logic [31:0]       dlv_data, rx_data, park_data;
   logic              sub_err, rx_empty, rx_full;
   logic              rx_pop = 1'b0;
   logic              park_pop = 1'b0;

   int vectors = 0;
   int miscompares = 0;
   bit done = 0;

   logic [31:0] chq [NCH][$];
   logic [31:0] rxq [$];
   logic [31:0] parkq [$];

   always #5 clk = ~clk;

   mbr_router #(.NCH(NCH), .PARK_DEPTH(PD), .RX_DEPTH(RD)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .chan_busy(chan_busy), .chan_avail(chan_avail), .rsp_data(rsp_data),
      .rsp_pop(rsp_pop), .dlv_valid(dlv_valid), .dlv_data(dlv_data),
      .sub_err(sub_err), .rx_pop(rx_pop), .rx_data(rx_data),
      .rx_empty(rx_empty), .rx_full(rx_full), .park_pop(park_pop),
      .park_data(park_data)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic drive_chan();
      for (int i = 0; i < NCH; i++) begin
         chan_avail[i] = (chq[i].size() > 0);
         rsp_data[i*32 +: 32] = (chq[i].size() > 0) ? chq[i][0] : 32'h0;
      end
   endtask

   function automatic logic [31:0] exp_stat();
      if (rd_addr != 8'hB8) return 32'h0;
      return {parkq.size() == PD, parkq.size() == 0, 22'd0, 8'(parkq.size())};
   endfunction

   // one clock of stimulus, model and comparison
   task automatic step();
      int pick;
      int ps0;
      logic [NCH-1:0] ep, edlv;
      logic [31:0] edata;
      logic eerr;
      logic [3:0] ch;
      drive_chan();
      #1;
      pick = -1;
      if (rxq.size() < RD)
         for (int i = NCH - 1; i >= 0; i--) if (chq[i].size() > 0) pick = i;
      ep = (pick >= 0) ? NCH'(1) << pick : '0;
      chk("R6 rsp_pop", 32'(rsp_pop), 32'(ep));
      chk("R10 rx_empty", 32'(rx_empty), 32'(rxq.size() == 0));
      chk("R7 rx_full", 32'(rx_full), 32'(rxq.size() == RD));
      if (rxq.size() > 0) chk("R10 rx_data", rx_data, rxq[0]);
      chk("R8 status", rd_data, exp_stat());
      if (parkq.size() > 0) chk("R3 park_data", park_data, parkq[0]);
      ps0 = parkq.size();
      edlv = '0; edata = '0; eerr = 1'b0;
      if (rx_pop && rxq.size() > 0) void'(rxq.pop_front());
      if (pick >= 0) rxq.push_back(chq[pick].pop_front());
      if (park_pop && ps0 > 0) void'(parkq.pop_front());
      if (wr_en && wr_addr >= 8'hA0 && wr_addr <= 8'hAC && wr_addr[1:0] == 2'b00) begin
         ch = wr_data[3:0];
         if (ps0 >= PD) eerr = 1'b1;
         else if (int'(ch) >= NCH) eerr = 1'b1;
         else if (chan_busy[ch]) parkq.push_back(wr_data);
         else begin
            edlv = NCH'(1) << ch;
            edata = wr_data;
         end
      end
      @(posedge clk);
      #1;
      chk("R2 dlv_valid", 32'(dlv_valid), 32'(edlv));
      if (edlv != '0) chk("R2 dlv_data", dlv_data, edata);
      chk("R4 R5 sub_err", 32'(sub_err), 32'(eerr));
   endtask

   task automatic submit(input logic [7:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      step();
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) step();
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      // R9: reset with a ready channel: nothing happens
      chq[4].push_back(32'hDEAD_0004);
      drive_chan();
      wr_en = 1'b1; wr_addr = 8'hA0; wr_data = 32'h0000_0001;
      repeat (3) @(posedge clk);
      #2;
      chk("R9 rsp_pop in reset", 32'(rsp_pop), 32'h0);
      chk("R9 dlv in reset", 32'(dlv_valid), 32'h0);
      chk("R9 err in reset", 32'(sub_err), 32'h0);
      chk("R9 rx_empty in reset", 32'(rx_empty), 32'h1);
      chk("R9 park status in reset", rd_data, 32'h4000_0000);
      wr_en = 1'b0;
      void'(chq[4].pop_front());
      drive_chan();
      rst_n = 1'b1;
      @(posedge clk); #1;
      idle(2);

      // R2: direct delivery to idle channels, word unchanged
      submit(8'hA0, 32'h1234_5670);
      submit(8'hA4, 32'hFFFF_FFF8);
      submit(8'hAC, 32'h0BAD_CAF3);
      idle(1);

      // R1: addresses outside the window, or misaligned, are ignored
      submit(8'h90, 32'h0000_0002);
      submit(8'hA2, 32'h0000_0002);
      submit(8'hB0, 32'h0000_0002);
      submit(8'h9C, 32'h0000_0002);

      // R5: channel numbers 9 and 15 are invalid
      submit(8'hA8, 32'hAAAA_0009);
      submit(8'hA0, 32'h5555_000F);

      // R3: busy channel parks the word
      chan_busy = 9'b0_0000_1000;
      submit(8'hA0, 32'hC0DE_0003);
      submit(8'hA4, 32'hC0DE_1003);
      submit(8'hA8, 32'h7777_0002);   // idle channel still delivers
      rd_addr = 8'h98;                // R8: other offset reads zero
      idle(1);
      rd_addr = 8'hB8;
      submit(8'hAC, 32'hC0DE_2003);
      submit(8'hA0, 32'hC0DE_3003);   // queue now full
      // R4: full queue drops even an idle target
      submit(8'hA0, 32'h9999_0001);
      submit(8'hA0, 32'h9999_0003);
      chan_busy = '0;
      // pop the parked words out in order
      park_pop = 1'b1;
      idle(2);
      submit(8'hA4, 32'h4444_0005);   // pop and submit together
      idle(3);
      park_pop = 1'b0;

      // R6: harvest order across several channels
      chq[2].push_back(32'h2000_0001); chq[2].push_back(32'h2000_0002);
      chq[2].push_back(32'h2000_0003);
      chq[0].push_back(32'h0000_00A1); chq[0].push_back(32'h0000_00A2);
      chq[5].push_back(32'h5000_0001);
      idle(3);
      chq[1].push_back(32'h1000_0001);  // lower index arrives mid-drain
      idle(4);

      // R10: host drains in order
      rx_pop = 1'b1;
      idle(8);
      rx_pop = 1'b0;

      // R7: fill the receive queue and hold it full
      for (int k = 0; k < 12; k++) chq[7].push_back(32'h7000_0000 + k);
      chq[8].push_back(32'h8888_8888);
      idle(14);
      rx_pop = 1'b1;
      idle(4);
      rx_pop = 1'b0;
      idle(3);
      rx_pop = 1'b1;
      idle(16);
      rx_pop = 1'b0;
      idle(2);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule